// File: doc/BRIEF.md
# Floppy DMA Register Window

This block is the host-visible register file of a floppy DMA path. A host bus reaches it with word-wide synchronous accesses. One address, the data port, is shared by six target registers. A separately written mode register decides which of them an access reaches: the DMA sector count, the DMA control word, or one of four disk-controller registers.

The disk controller itself lives outside this block. It is seen only through its command output, a one-cycle command-start pulse, a status input and an interrupt input. Reading the disk status while the controller's interrupt is idle raises a level meant for bit 5 of a general-purpose input port. That input is active low, so a high level means "no request".

The block also holds a read-only DMA status word and a 24-bit byte DMA address, kept as three byte registers. Every data-port access reports a fixed wait-state count to the bus side.

Top module: `fdma_regwin`

## Requirements
- R1: After reset every register reads zero except the DMA status word (index 2), which reads 1. `dma_addr`, `dsk_cmd_stb`, `gpi_dsk_n` and `io_wait` are all 0.
- R2: While mode bit 4 is 1, data-port (index 0) reads and writes reach the sector-count register, whatever mode bits 3:1 hold.
- R3: While mode bit 4 is 0 and mode bit 3 is 1, the data port reaches the DMA control register.
- R4: While mode bits 4 and 3 are 0, mode bits 2:1 select the disk register. 01 selects track, 10 selects sector and 11 selects data. These are 8-bit registers: a read returns zero in bits 15:8, and each value is driven on its own output.
- R5: A data-port write with mode bits 4:1 all zero loads `dsk_cmd` from bits 7:0. `dsk_cmd_stb` is then high for exactly the following cycle. A write to any other target gives no pulse.
- R6: A data-port read with mode bits 4:1 all zero returns `dsk_status`. If `dsk_irq` is 0 during that read, `gpi_dsk_n` is 1 from the next cycle on. If `dsk_irq` is 1 in a cycle, `gpi_dsk_n` is 0 in the next cycle.
- R7: The DMA status word (index 2) reads 1, and writes to it have no effect.
- R8: Indices 3, 4 and 5 hold the high, middle and low DMA address bytes. Each one is written from bits 7:0 and reads back zero-extended. `dma_addr` is {high, middle, low}.
- R9: In the cycle after any data-port access (read or write), `io_wait` is 4. After any other cycle it is 0.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_re` and holds until the next read. A mode write steers the very next access. The mode register (index 1) reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_addr | input | AW (3) | word register index |
| bus_wdata | input | DW (16) | write data |
| bus_we | input | 1 | write enable |
| bus_re | input | 1 | read enable |
| bus_rdata | output | DW (16) | registered read data |
| io_wait | output | WW (3) | wait states owed by the previous access |
| dsk_cmd | output | 8 | last disk command |
| dsk_cmd_stb | output | 1 | one-cycle command-start pulse |
| dsk_track | output | 8 | disk track register |
| dsk_sector | output | 8 | disk sector register |
| dsk_data | output | 8 | disk data register |
| dsk_status | input | 8 | disk controller status |
| dsk_irq | input | 1 | disk controller interrupt, active high |
| gpi_dsk_n | output | 1 | active-low request level for general input bit 5 |
| dma_addr | output | 24 | DMA byte address |

## Verification
Every result here comes from a single register stage. Read data, `io_wait`, `dsk_cmd_stb`, `dsk_cmd` and `gpi_dsk_n` are therefore due one cycle after the access that causes them. Each bench task drives its access at a falling edge and samples 1 ns after the next rising edge. The strobe is sampled again one cycle later to confirm that it has fallen. Register contents and the interrupt-level behaviour are checked with separate accesses that read through the data port, so each effect is seen at the ports.

// File: rtl/fdma_regwin.sv
module fdma_regwin #(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int WAIT_DATA = 4,
  localparam int WW = $clog2(WAIT_DATA + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic [WW-1:0] io_wait,
  output logic [7:0]    dsk_cmd,
  output logic          dsk_cmd_stb,
  output logic [7:0]    dsk_track,
  output logic [7:0]    dsk_sector,
  output logic [7:0]    dsk_data,
  input  logic [7:0]    dsk_status,
  input  logic          dsk_irq,
  output logic          gpi_dsk_n,
  output logic [23:0]   dma_addr
);
  localparam logic [AW-1:0] IX_PORT = AW'(0);
  localparam logic [AW-1:0] IX_MODE = AW'(1);
  localparam logic [AW-1:0] IX_STAT = AW'(2);
  localparam logic [AW-1:0] IX_AHI  = AW'(3);
  localparam logic [AW-1:0] IX_AMID = AW'(4);
  localparam logic [AW-1:0] IX_ALO  = AW'(5);

  logic [DW-1:0] mode_q, scnt_q, ctrl_q, stat_q, rd_mux;
  logic [7:0] cmd_q, trk_q, sec_q, dat_q, ahi_q, amid_q, alo_q;
  logic [DW-1:0] rdata_q;
  logic [WW-1:0] wait_q;
  logic stb_q, gpi_q;

  wire port_hit = (bus_addr == IX_PORT);
  wire to_scnt  = mode_q[4];
  wire to_ctrl  = !mode_q[4] && mode_q[3];
  wire to_disk  = !mode_q[4] && !mode_q[3];
  wire [1:0] fsel = mode_q[2:1];
  wire port_wr  = bus_we && port_hit;
  wire port_rd  = bus_re && port_hit;
  wire cmd_wr   = port_wr && to_disk && (fsel == 2'd0);
  wire stat_rd  = port_rd && to_disk && (fsel == 2'd0);

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      IX_PORT: begin
        if (to_scnt)      rd_mux = scnt_q;
        else if (to_ctrl) rd_mux = ctrl_q;
        else begin
          case (fsel)
            2'd0: rd_mux = DW'(dsk_status);
            2'd1: rd_mux = DW'(trk_q);
            2'd2: rd_mux = DW'(sec_q);
            default: rd_mux = DW'(dat_q);
          endcase
        end
      end
      IX_MODE: rd_mux = mode_q;
      IX_STAT: rd_mux = stat_q;
      IX_AHI:  rd_mux = DW'(ahi_q);
      IX_AMID: rd_mux = DW'(amid_q);
      IX_ALO:  rd_mux = DW'(alo_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      scnt_q <= '0;
      ctrl_q <= '0;
      stat_q <= DW'(1);
      cmd_q  <= '0;
      trk_q  <= '0;
      sec_q  <= '0;
      dat_q  <= '0;
      ahi_q  <= '0;
      amid_q <= '0;
      alo_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        IX_PORT: begin
          if (to_scnt)      scnt_q <= bus_wdata;
          else if (to_ctrl) ctrl_q <= bus_wdata;
          else begin
            case (fsel)
              2'd0: cmd_q <= bus_wdata[7:0];
              2'd1: trk_q <= bus_wdata[7:0];
              2'd2: sec_q <= bus_wdata[7:0];
              default: dat_q <= bus_wdata[7:0];
            endcase
          end
        end
        IX_MODE: mode_q <= bus_wdata;
        IX_AHI:  ahi_q  <= bus_wdata[7:0];
        IX_AMID: amid_q <= bus_wdata[7:0];
        IX_ALO:  alo_q  <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      wait_q  <= '0;
      stb_q   <= 1'b0;
      gpi_q   <= 1'b0;
    end else begin
      if (bus_re) rdata_q <= rd_mux;
      wait_q <= (port_wr || port_rd) ? WW'(WAIT_DATA) : '0;
      stb_q  <= cmd_wr;
      if (dsk_irq)      gpi_q <= 1'b0;
      else if (stat_rd) gpi_q <= 1'b1;
    end
  end

  assign bus_rdata   = rdata_q;
  assign io_wait     = wait_q;
  assign dsk_cmd     = cmd_q;
  assign dsk_cmd_stb = stb_q;
  assign dsk_track   = trk_q;
  assign dsk_sector  = sec_q;
  assign dsk_data    = dat_q;
  assign gpi_dsk_n   = gpi_q;
  assign dma_addr    = {ahi_q, amid_q, alo_q};
endmodule

// File: rtl/fdma_regwin_chk.sv
module fdma_regwin_chk #(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int WW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic          bus_re,
  input logic [DW-1:0] bus_rdata,
  input logic [WW-1:0] io_wait,
  input logic [DW-1:0] mode,
  input logic [7:0]    dsk_cmd,
  input logic          dsk_cmd_stb,
  input logic          dsk_irq,
  input logic          gpi_dsk_n
);
  wire on_port = (bus_addr == '0);

  // R5
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && on_port && (mode[4:1] == 4'd0) |=> dsk_cmd_stb && dsk_cmd == $past(bus_wdata[7:0]));

  // R5
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_cmd_stb |=> !dsk_cmd_stb);

  // R9
  port_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we || bus_re) && on_port |=> io_wait == WW'(4));

  // R9
  idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_we || bus_re) && on_port) |=> io_wait == '0);

  // R6
  gpi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && on_port && (mode[4:1] == 4'd0) && !dsk_irq |=> gpi_dsk_n);

  // R6
  gpi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_irq |=> !gpi_dsk_n);

  // R7
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && (bus_addr == AW'(2)) |=> bus_rdata == DW'(1));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

bind fdma_regwin fdma_regwin_chk #(.AW(AW), .DW(DW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .io_wait(io_wait),
  .mode(mode_q), .dsk_cmd(dsk_cmd), .dsk_cmd_stb(dsk_cmd_stb),
  .dsk_irq(dsk_irq), .gpi_dsk_n(gpi_dsk_n)
);

// File: tb/sim_fdma_regwin.sv
`timescale 1ns/1ps
module sim_fdma_regwin;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic [2:0] io_wait;
  logic [7:0] dsk_cmd, dsk_track, dsk_sector, dsk_data;
  logic dsk_cmd_stb, gpi_dsk_n;
  logic [7:0] dsk_status = '0;
  logic dsk_irq = 1'b0;
  logic [23:0] dma_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fdma_regwin u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .io_wait(io_wait),
    .dsk_cmd(dsk_cmd), .dsk_cmd_stb(dsk_cmd_stb), .dsk_track(dsk_track),
    .dsk_sector(dsk_sector), .dsk_data(dsk_data), .dsk_status(dsk_status),
    .dsk_irq(dsk_irq), .gpi_dsk_n(gpi_dsk_n), .dma_addr(dma_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [2:0] last_wait;

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    last_wait = io_wait;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk); #1;
    d = bus_rdata;
    last_wait = io_wait;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 dma_addr", dma_addr, 24'h0);
    check("R1 stb", dsk_cmd_stb, 1'b0);
    check("R1 gpi", gpi_dsk_n, 1'b0);
    check("R1 wait", io_wait, 3'd0);
    rd(3'd1, v); check("R1 mode", v, 16'h0);
    rd(3'd2, v); check("R1 status", v, 16'h1);
    rd(3'd3, v); check("R1 addr hi", v, 16'h0);
    wr(3'd1, 16'h0010); rd(3'd0, v); check("R1 sector count", v, 16'h0);
  endtask

  task automatic t_sector_ctrl();
    logic [15:0] v;
    wr(3'd1, 16'h001E);
    wr(3'd0, 16'h1234);
    rd(3'd0, v); check("R2 sector count with low bits set", v, 16'h1234);
    rd(3'd1, v); check("R10 mode readback", v, 16'h001E);
    wr(3'd1, 16'h0008);
    rd(3'd0, v); check("R3 control untouched", v, 16'h0);
    wr(3'd0, 16'hBEEF);
    rd(3'd0, v); check("R3 control", v, 16'hBEEF);
    wr(3'd1, 16'h000E);
    rd(3'd0, v); check("R3 bit3 with bits2:1", v, 16'hBEEF);
    wr(3'd1, 16'h0018);
    rd(3'd0, v); check("R2 bit4 over bit3", v, 16'h1234);
  endtask

  task automatic t_disk();
    logic [15:0] v;
    wr(3'd1, 16'h0002); wr(3'd0, 16'h01A5);
    wr(3'd1, 16'h0004); wr(3'd0, 16'h0007);
    wr(3'd1, 16'h0006); wr(3'd0, 16'hFF3C);
    check("R4 track out", dsk_track, 8'hA5);
    check("R4 sector out", dsk_sector, 8'h07);
    check("R4 data out", dsk_data, 8'h3C);
    wr(3'd1, 16'h0002); rd(3'd0, v); check("R4 track read", v, 16'h00A5);
    wr(3'd1, 16'h0004); rd(3'd0, v); check("R4 sector read", v, 16'h0007);
    wr(3'd1, 16'h0006); rd(3'd0, v); check("R4 data read", v, 16'h003C);
  endtask

  task automatic t_cmd();
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h0011);
    check("R5 no pulse on track write", dsk_cmd_stb, 1'b0);
    wr(3'd1, 16'h0000);
    check("R5 no pulse on mode write", dsk_cmd_stb, 1'b0);
    @(negedge clk);
    bus_addr = 3'd0; bus_wdata = 16'h0080; bus_we = 1'b1;
    @(posedge clk); #1;
    check("R5 pulse high", dsk_cmd_stb, 1'b1);
    check("R5 command value", dsk_cmd, 8'h80);
    @(negedge clk); bus_we = 1'b0;
    @(posedge clk); #1;
    check("R5 pulse single cycle", dsk_cmd_stb, 1'b0);
  endtask

  task automatic t_status();
    logic [15:0] v;
    wr(3'd1, 16'h0000);
    dsk_status = 8'h5A; dsk_irq = 1'b1;
    rd(3'd0, v);
    check("R6 status value", v, 16'h005A);
    check("R6 no set while irq", gpi_dsk_n, 1'b0);
    dsk_irq = 1'b0;
    rd(3'd0, v);
    check("R6 set after read", gpi_dsk_n, 1'b1);
    wr(3'd1, 16'h0002); rd(3'd0, v);
    check("R6 holds", gpi_dsk_n, 1'b1);
    @(negedge clk); dsk_irq = 1'b1;
    @(posedge clk); #1;
    check("R6 cleared by irq", gpi_dsk_n, 1'b0);
    @(negedge clk); dsk_irq = 1'b0;
  endtask

  task automatic t_stat_addr();
    logic [15:0] v;
    wr(3'd2, 16'hFFFF);
    rd(3'd2, v); check("R7 status write ignored", v, 16'h0001);
    wr(3'd3, 16'h1F12); wr(3'd4, 16'h0034); wr(3'd5, 16'hAB56);
    check("R8 dma_addr", dma_addr, 24'h123456);
    rd(3'd3, v); check("R8 high byte", v, 16'h0012);
    rd(3'd5, v); check("R8 low byte", v, 16'h0056);
  endtask

  task automatic t_wait_read();
    logic [15:0] v;
    wr(3'd1, 16'h0008);
    check("R9 mode write no wait", last_wait, 3'd0);
    wr(3'd0, 16'h4321);
    check("R9 port write wait", last_wait, 3'd4);
    rd(3'd0, v);
    check("R9 port read wait", last_wait, 3'd4);
    check("R10 read registered", v, 16'h4321);
    @(posedge clk); #1;
    check("R9 idle wait", io_wait, 3'd0);
    check("R10 rdata holds", bus_rdata, 16'h4321);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_sector_ctrl();
    t_disk();
    t_cmd();
    t_status();
    t_stat_addr();
    t_wait_read();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule